// File: doc/BRIEF.md
# Priority Interrupt Selection Unit

This purely combinational unit decides, for one hart, whether an interrupt must be taken now and which source it is. It takes the pending vector, the enable vector, the delegation mask, the current privilege level and the global machine and supervisor interrupt-enable bits. It returns a take flag and a trap cause word.

The unit forms the candidate set of sources that are both pending and enabled, then splits it into two tiers. Sources that are not delegated follow the machine-level gate. Delegated sources follow the supervisor-level gate. The surviving sources are merged, and a lowest-index priority pick selects the winner. The cause word marks an interrupt in its top bit and carries the winning index in its low bits.

The unit holds no state, so there are no states or transitions to name. The privilege input uses user = 0, supervisor = 1 and machine = 3. The value 2 is never applied.

Top module: `irqsel_top`

## Requirements
- R1: A source is a candidate only when its bit is set in both `pend_i` and `en_i`. A source missing either bit is never selected.
- R2: A candidate whose `deleg_i` bit is 0 is allowed when `priv_i` is 0 or 1. It is also allowed when `priv_i` is 3 and `m_ie_i` is 1. It is blocked when `priv_i` is 3 and `m_ie_i` is 0. `s_ie_i` has no effect on it.
- R3: A candidate whose `deleg_i` bit is 1 is allowed when `priv_i` is 0. It is also allowed when `priv_i` is 1 and `s_ie_i` is 1. It is always blocked when `priv_i` is 3. `m_ie_i` has no effect on it.
- R4: The final set is the union of the allowed sources from both tiers, so either tier alone can raise `take_o`.
- R5: When several sources are in the final set, the one with the lowest bit index wins.
- R6: When an interrupt is taken, `cause_o[CAUSE_W-1]` is 1 and `cause_o[IDX_W-1:0]` holds the winning index. All other bits are 0.
- R7: When the final set is empty, `take_o` is 0 and `cause_o` is all zeros.
- R8: The outputs depend only on the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pend_i | input | NUM_IRQ | Pending interrupt sources |
| en_i | input | NUM_IRQ | Per-source enable |
| deleg_i | input | NUM_IRQ | 1 = source is delegated to the supervisor tier |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_ie_i | input | 1 | Global machine interrupt enable |
| s_ie_i | input | 1 | Global supervisor interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| cause_o | output | CAUSE_W | Interrupt cause: top bit set, winning index in the low bits |

## Verification
Both results, `take_o` and `cause_o`, are due in the same cycle as the inputs that produce them, because no register lies on any path. The bench changes every input on a falling clock edge and samples 2 ns later, well before the next rising edge. This leaves the combinational paths time to settle while keeping each sample clear of the active edge. Every sample is compared against a bench function built from the requirements. The comparison covers every privilege and enable combination over random vectors, plus directed cases at the lowest and highest index and at the empty set.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_MACH  = 2'd3
    } priv_e;
endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate
    import irqsel_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_ie_i,
    input  logic               s_ie_i,
    output logic [NUM_IRQ-1:0] live_o
);
    priv_e              lvl;
    logic               mach_tier_ok;
    logic               sup_tier_ok;
    logic [NUM_IRQ-1:0] cand;
    logic [NUM_IRQ-1:0] mach_part;
    logic [NUM_IRQ-1:0] sup_part;

    assign lvl  = priv_e'(priv_i);
    assign cand = pend_i & en_i;

    always_comb begin
        unique case (lvl)
            PRIV_USER: begin
                mach_tier_ok = 1'b1;
                sup_tier_ok  = 1'b1;
            end
            PRIV_SUPER: begin
                mach_tier_ok = 1'b1;
                sup_tier_ok  = s_ie_i;
            end
            PRIV_MACH: begin
                mach_tier_ok = m_ie_i;
                sup_tier_ok  = 1'b0;
            end
            default: begin
                mach_tier_ok = 1'b0;
                sup_tier_ok  = 1'b0;
            end
        endcase
    end

    always_comb begin
        mach_part = cand & ~deleg_i & {NUM_IRQ{mach_tier_ok}};
        sup_part  = cand &  deleg_i & {NUM_IRQ{sup_tier_ok}};
        live_o    = mach_part | sup_part;
    end

    always_comb begin
        // R1
        live_subset_chk: assert ((live_o & ~(pend_i & en_i)) == '0)
            else $error("live source not pending and enabled");
        // R3
        mach_blocks_deleg_chk: assert (!(priv_i == 2'd3) || ((live_o & deleg_i) == '0))
            else $error("delegated source live at machine level");
        // R2
        mach_mie_low_chk: assert (!(priv_i == 2'd3 && !m_ie_i) || (live_o == '0))
            else $error("source live at machine level with machine enable low");
    end
endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick #(
    parameter int NUM_IRQ = 16,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_IRQ-1:0] vec_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [NUM_IRQ-1:0] lower_any;
    logic [NUM_IRQ-1:0] first_hot;

    assign lower_any[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < NUM_IRQ; g++) begin : g_chain
            assign lower_any[g] = lower_any[g-1] | vec_i[g-1];
        end
    endgenerate

    assign first_hot = vec_i & ~lower_any;
    assign any_o     = |vec_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (first_hot[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    always_comb begin
        // R5
        single_winner_chk: assert ($onehot0(first_hot))
            else $error("more than one winner");
    end
endmodule

// File: rtl/irqsel_cause.sv
module irqsel_cause #(
    parameter int CAUSE_W = 32,
    parameter int IDX_W   = 4
) (
    input  logic               valid_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int GAP_W = CAUSE_W - 1 - IDX_W;

    always_comb begin
        cause_o = '0;
        if (valid_i) begin
            cause_o = {1'b1, {GAP_W{1'b0}}, idx_i};
        end
    end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top #(
    parameter int NUM_IRQ = 16,
    parameter int CAUSE_W = 32
) (
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_ie_i,
    input  logic               s_ie_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] live_set;
    logic               any_live;
    logic [IDX_W-1:0]   win_idx;
    logic [NUM_IRQ-1:0] below_mask;

    irqsel_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .pend_i (pend_i),
        .en_i   (en_i),
        .deleg_i(deleg_i),
        .priv_i (priv_i),
        .m_ie_i (m_ie_i),
        .s_ie_i (s_ie_i),
        .live_o (live_set)
    );

    irqsel_pick #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
        .vec_i(live_set),
        .any_o(any_live),
        .idx_o(win_idx)
    );

    irqsel_cause #(.CAUSE_W(CAUSE_W), .IDX_W(IDX_W)) u_cause (
        .valid_i(any_live),
        .idx_i  (win_idx),
        .cause_o(cause_o)
    );

    assign take_o     = any_live;
    assign below_mask = (NUM_IRQ'(1) << win_idx) - NUM_IRQ'(1);

    always_comb begin
        // R5
        winner_live_chk: assert (!take_o || live_set[win_idx])
            else $error("chosen source not live");
        // R5
        nothing_lower_chk: assert (!take_o || ((live_set & below_mask) == '0))
            else $error("lower live source skipped");
        // R6
        cause_flag_chk: assert (take_o == cause_o[CAUSE_W-1])
            else $error("cause top bit disagrees with take");
        // R7
        idle_zero_chk: assert (take_o || (cause_o == '0))
            else $error("cause not zero when idle");
    end
endmodule

// File: tb/test_irqsel_top.sv
module test_irqsel_top;
    localparam int N  = 16;
    localparam int CW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic [N-1:0]  pend, en, dlg;
    logic [1:0]    priv;
    logic          mie, sie;
    logic          take;
    logic [CW-1:0] cause;
    int            checks   = 0;
    int            failures = 0;
    bit            done     = 1'b0;

    always #4 clk = ~clk;

    irqsel_top #(.NUM_IRQ(N), .CAUSE_W(CW)) i_irqsel_top (
        .pend_i(pend), .en_i(en), .deleg_i(dlg), .priv_i(priv),
        .m_ie_i(mie), .s_ie_i(sie), .take_o(take), .cause_o(cause)
    );

    function automatic logic [CW:0] expect_out(
        logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] d,
        logic [1:0] pv, logic mi, logic si);
        logic [N-1:0] fin;
        logic [CW:0]  r;
        logic         mok, sok;
        mok = (pv == 2'd0) || (pv == 2'd1) || (pv == 2'd3 && mi);
        sok = (pv == 2'd0) || (pv == 2'd1 && si);
        fin = '0;
        for (int i = 0; i < N; i++) begin
            if (p[i] && e[i] && ((d[i] && sok) || (!d[i] && mok))) fin[i] = 1'b1;
        end
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fin[i]) r = {1'b1, 1'b1, {(CW-1-IW){1'b0}}, IW'(i)};
        end
        return r;
    endfunction

    task automatic apply_and_check(string req, logic [N-1:0] p, logic [N-1:0] e,
                                   logic [N-1:0] d, logic [1:0] pv, logic mi, logic si);
        logic [CW:0] ex;
        @(negedge clk);
        pend = p; en = e; dlg = d; priv = pv; mie = mi; sie = si;
        #2;
        ex = expect_out(p, e, d, pv, mi, si);
        checks++;
        if ({take, cause} !== ex) begin
            failures++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h (priv=%0d mie=%0b sie=%0b)",
                     req, take, cause, ex[CW], ex[CW-1:0], pv, mi, si);
        end
    endtask

    initial begin
        pend = '0; en = '0; dlg = '0; priv = 2'd3; mie = 1'b0; sie = 1'b0;
        #2;
        checks++;
        if (take !== 1'b0 || cause !== '0) begin
            failures++;
            $display("FAIL R7 initial: take=%0b cause=%h expected 0/0", take, cause);
        end
        // R8: outputs follow inputs within the same cycle
        apply_and_check("R8 same-cycle", 16'h0010, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
        // R1: pending without enable, enable without pending
        apply_and_check("R1 pend-no-en", 16'hFFFF, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1);
        apply_and_check("R1 en-no-pend", 16'h0000, 16'hFFFF, 16'hFFFF, 2'd0, 1'b1, 1'b1);
        apply_and_check("R1 disjoint", 16'h00F0, 16'h0F0F, 16'h0000, 2'd1, 1'b1, 1'b1);
        // R2: machine level, non-delegated, machine enable low then high
        apply_and_check("R2 mach-mie0", 16'h0008, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1);
        apply_and_check("R2 mach-mie1", 16'h0008, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0);
        apply_and_check("R2 super-mie0", 16'h0008, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0);
        // R3: delegated source at each level
        apply_and_check("R3 mach-deleg", 16'h0004, 16'hFFFF, 16'hFFFF, 2'd3, 1'b1, 1'b1);
        apply_and_check("R3 super-sie0", 16'h0004, 16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b0);
        apply_and_check("R3 super-sie1", 16'h0004, 16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 1'b1);
        apply_and_check("R3 user", 16'h0004, 16'hFFFF, 16'hFFFF, 2'd0, 1'b0, 1'b0);
        // R4: delegated blocked, non-delegated high index still wins
        apply_and_check("R4 union", 16'h8001, 16'hFFFF, 16'h0001, 2'd1, 1'b1, 1'b0);
        // R5: lowest index wins, index 0 and top index
        apply_and_check("R5 all", 16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
        apply_and_check("R5 mid", 16'hA0A0, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0);
        // R6: top index in the cause field
        apply_and_check("R6 top-index", 16'h8000, 16'h8000, 16'h0000, 2'd3, 1'b1, 1'b0);
        // R7: empty after blocking
        apply_and_check("R7 empty", 16'h0000, 16'h0000, 16'h0000, 2'd1, 1'b1, 1'b1);

        void'($urandom(32'd20240611));
        for (int k = 0; k < 200; k++) begin
            logic [N-1:0] rp, re, rd;
            rp = N'($urandom()) & N'($urandom());
            re = N'($urandom());
            rd = N'($urandom());
            for (int pl = 0; pl < 3; pl++) begin
                for (int en2 = 0; en2 < 4; en2++) begin
                    logic [1:0] pv;
                    pv = (pl == 2) ? 2'd3 : 2'(pl);
                    apply_and_check("R4/R5/R6 random", rp, re, rd, pv, en2[0], en2[1]);
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule